// File: doc/BRIEF.md
# EPROM margin-mode programming sequencer

This block sits on the programmer side of a socket holding a byte-wide UV or one-time-programmable EPROM. It walks the device's whole address range and burns each byte with fixed-width program pulses. After every pulse it reads the byte back, with the device's internal margin circuit switched on, so that no extra overprogram pulse is needed. Once the last byte verifies, it switches the margin circuit off and reads the whole array back twice: first at a raised supply, then at a lowered one. The block does not generate any voltage. It only drives level-select lines for the supply, the program supply and the high voltage on A9, and it spaces every change on those lines by parameterised clock counts.

The data to be written comes from a byte source. The sequencer drives an address and the source returns the wanted byte for that address in the same cycle. The sampled device data bus comes back on a separate input. A run starts with a one-cycle `start`. It ends in either a done state or a fail state, and the fail state reports the address and a cause code. Both end states hold until the next `start`.

Top module: `eprom_burn_seq`

## Requirements
- R1: Out of reset, and in the idle, done and fail states, chip enable is high (`ce_n`=1), the data driver is off, `vpp_sel`=01 (logic high), `a9_hv`=0, `a10_lvl`=0 and `vcc_sel`=00 (nominal supply).
- R2: Margin set happens before the first pulse, at `vcc_sel`=01 (program supply level). The sequence is: `a9_hv` rises, then T2 cycles later `vpp_sel` goes to 10 (program voltage), then T2 cycles later `ce_n` falls. `a10_lvl` goes high T1 cycles after that and stays high T1 cycles before `ce_n` rises. The same sequence with `a10_lvl` held low is the margin reset.
- R3: For a program pulse, address and data are driven for T2 cycles at program voltage before `ce_n` falls. `ce_n` then stays low for exactly TP cycles. Data stays driven T2 cycles after `ce_n` rises, and the address does not change while `ce_n` is low.
- R4: Every byte is read back once before any pulse and again after every pulse. The read-back runs in margin mode with `vpp_sel`=00 (output enable low) and the driver off. The byte is sampled TV cycles after `ce_n` falls.
- R5: A byte whose read-back equals the source byte gets no further pulse, and the address advances. A byte that already reads as wanted (for example an erased cell asked for FF) gets zero pulses.
- R6: If a byte still mismatches after MAX_PULSES pulses, the run ends in fail with `fail_code`=01 and `fail_addr` set to that address.
- R7: If the source byte has a 1 in a bit where the device already reads 0, the run ends at once in fail with `fail_code`=10, and that byte gets no pulse.
- R8: After the last address verifies, margin reset runs before any final read-back.
- R9: The final read-back covers every address, first at `vcc_sel`=10 (raised supply) and then at `vcc_sel`=11 (lowered supply), in each case with margin off. A mismatch ends the run in fail with `fail_code`=11 and `fail_addr` set to that address.
- R10: When both read-back passes match, `done` rises and stays high. `done` and `fail` and the fail fields hold until `start`, and `start` in the done or fail state begins a fresh run.
- R11: The data driver is off in every read state, that is whenever `vpp_sel`=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle run request |
| src_addr | output | AW | Address of the byte wanted from the source |
| src_data | input | DW | Wanted byte for `src_addr`, same cycle |
| dev_addr | output | AW | Device address lines |
| dq_out | output | DW | Data to drive onto the device data bus |
| dq_oe | output | 1 | Data bus driver enable |
| dq_in | input | DW | Sampled device data bus |
| ce_n | output | 1 | Device chip enable, active low |
| vpp_sel | output | 2 | Output-enable/program-supply level: 00 low, 01 logic high, 10 program voltage |
| a9_hv | output | 1 | Select high voltage on A9 |
| a10_lvl | output | 1 | A10 level during margin set (1) or reset (0) |
| vcc_sel | output | 2 | Supply select: 00 nominal, 01 program, 10 raised, 11 lowered |
| done | output | 1 | Run finished with every byte correct |
| fail | output | 1 | Run stopped on an error |
| fail_code | output | 2 | 01 retry limit, 10 unprogrammable byte, 11 read-back mismatch |
| fail_addr | output | AW | Address at which the run stopped |

## Verification
The assertions assume that `src_data` is a pure function of `src_addr`, so the wanted byte cannot change while a pulse or a verify is in flight. They also assume that `start` only arrives when no run is active. The bench meets both assumptions: the source is a fixed array indexed by the driven address and is rewritten only while the block sits in done or fail, and `start` is raised only in those states or in idle. The device model drives `dq_in` only while chip enable and output enable are both low and the driver is off, so the values sampled outside read windows are never used.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

   typedef enum logic [4:0] {
      S_IDLE, S_MG_A9, S_MG_VPP, S_MG_CEL, S_MG_A10, S_MG_CEH, S_MG_END,
      S_B_RDSET, S_B_RDCE, S_B_RDEND, S_B_LOAD, S_B_PULSE, S_B_HOLD,
      S_RB_VCC, S_RB_RD, S_RB_END, S_DONE, S_FAIL
   } seq_st_t;

   typedef enum logic [1:0] {
      VPP_LOW  = 2'b00,
      VPP_HIGH = 2'b01,
      VPP_PROG = 2'b10
   } vpp_lvl_t;

   typedef enum logic [1:0] {
      VCC_NOM  = 2'b00,
      VCC_PROG = 2'b01,
      VCC_HI   = 2'b10,
      VCC_LO   = 2'b11
   } vcc_lvl_t;

   typedef enum logic [1:0] {
      ERR_NONE     = 2'b00,
      ERR_RETRY    = 2'b01,
      ERR_UNPROG   = 2'b10,
      ERR_READBACK = 2'b11
   } err_t;

endpackage

// File: rtl/eprom_seq_timer.sv
module eprom_seq_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R3: a nonzero wait cannot finish in the cycle after it is loaded
   assert_wait_not_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/eprom_seq_cmp.sv
module eprom_seq_cmp #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] want,
   input  logic [DW-1:0] got,
   output logic          match,
   output logic          unprog
);

   logic [DW-1:0] stuck;

   // a wanted 1 over a cell already at 0 can never be reached by pulsing
   for (genvar i = 0; i < DW; i++) begin : g_bit
      assign stuck[i] = want[i] & ~got[i];
   end

   assign match  = (want == got);
   assign unprog = |stuck;

   // R7: a byte that cannot be programmed never counts as a match
   always_comb begin
      assert_unprog_not_match_R7: assert (!(unprog && match));
   end

endmodule

// File: rtl/eprom_seq_addr.sv
module eprom_seq_addr #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [AW-1:0] addr,
   output logic          last
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr <= '0;
      else if (clr)  addr <= '0;
      else if (inc)  addr <= addr + 1'b1;
   end

   assign last = &addr;

   // R5: an advance moves to the next address only
   assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> (addr == $past(addr) + AW'(1)));

endmodule

// File: rtl/eprom_burn_seq.sv
module eprom_burn_seq
   import eprom_seq_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 8,
   parameter int T1_CYC     = 125,
   parameter int T2_CYC     = 250,
   parameter int TP_CYC     = 12500,
   parameter int TV_CYC     = 125,
   parameter int TZ_CYC     = 1,
   parameter int MAX_PULSES = 25
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic [AW-1:0] src_addr,
   input  logic [DW-1:0] src_data,
   output logic [AW-1:0] dev_addr,
   output logic [DW-1:0] dq_out,
   output logic          dq_oe,
   input  logic [DW-1:0] dq_in,
   output logic          ce_n,
   output logic [1:0]    vpp_sel,
   output logic          a9_hv,
   output logic          a10_lvl,
   output logic [1:0]    vcc_sel,
   output logic          done,
   output logic          fail,
   output logic [1:0]    fail_code,
   output logic [AW-1:0] fail_addr
);

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int DMAX  = imax(imax(imax(T1_CYC, T2_CYC), imax(TP_CYC, TV_CYC)), TZ_CYC);
   localparam int CW    = $clog2(DMAX + 1) + 1;
   localparam int TRY_W = $clog2(MAX_PULSES + 1);

   if (T1_CYC < 1 || T2_CYC < 1 || TP_CYC < 1 || TV_CYC < 1 || TZ_CYC < 1) begin : g_bad_wait
      $error("every wait count must be at least one cycle");
   end
   if (T2_CYC < T1_CYC) begin : g_bad_order
      $error("T2_CYC must not be shorter than T1_CYC");
   end
   if (MAX_PULSES < 1 || AW < 1 || DW < 1) begin : g_bad_size
      $error("MAX_PULSES, AW and DW must be positive");
   end

   seq_st_t         st, st_nxt;
   vpp_lvl_t        vpp_q;
   vcc_lvl_t        vcc_q;
   err_t            err_q, err_v;
   logic            tmr_exp, tmr_load;
   logic [CW-1:0]   tmr_val;
   logic            a_clr, a_inc, a_last;
   logic            t_clr, t_inc, cap, mg_on, mg_off, rb_next, rb_clr, err_ld;
   logic            mg_q, rb_q;
   logic [TRY_W-1:0] tries;
   logic [DW-1:0]   rd_q;
   logic            cmp_match, cmp_unprog;
   logic [CW-1:0]   pw;

   // ---------------- wait length per state ----------------
   function automatic logic [CW-1:0] wait_of(input seq_st_t s);
      int d;
      unique case (s)
         S_MG_A9, S_MG_VPP, S_MG_CEH, S_MG_END,
         S_B_RDSET, S_B_LOAD, S_B_HOLD, S_RB_VCC: d = T2_CYC;
         S_MG_CEL, S_MG_A10:                      d = T1_CYC;
         S_B_PULSE:                               d = TP_CYC;
         S_B_RDCE, S_RB_RD:                       d = TV_CYC;
         S_B_RDEND, S_RB_END:                     d = TZ_CYC;
         default:                                 d = 1;
      endcase
      return CW'(d - 1);
   endfunction

   assign tmr_load = (st_nxt != st);
   assign tmr_val  = wait_of(st_nxt);

   eprom_seq_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
   );

   eprom_seq_addr #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .clr(a_clr), .inc(a_inc), .addr(dev_addr), .last(a_last)
   );

   eprom_seq_cmp #(.DW(DW)) u_cmp (
      .want(src_data), .got(rd_q), .match(cmp_match), .unprog(cmp_unprog)
   );

   // ---------------- next state and strobes ----------------
   always_comb begin
      st_nxt  = st;
      a_clr   = 1'b0;
      a_inc   = 1'b0;
      t_clr   = 1'b0;
      t_inc   = 1'b0;
      cap     = 1'b0;
      mg_on   = 1'b0;
      mg_off  = 1'b0;
      rb_next = 1'b0;
      rb_clr  = 1'b0;
      err_ld  = 1'b0;
      err_v   = ERR_NONE;
      if (tmr_exp) begin
         unique case (st)
            S_IDLE, S_DONE, S_FAIL: begin
               if (start) begin
                  st_nxt = S_MG_A9;
                  a_clr  = 1'b1;
                  t_clr  = 1'b1;
                  mg_on  = 1'b1;
                  rb_clr = 1'b1;
               end
            end
            S_MG_A9:  st_nxt = S_MG_VPP;
            S_MG_VPP: st_nxt = S_MG_CEL;
            S_MG_CEL: st_nxt = S_MG_A10;
            S_MG_A10: st_nxt = S_MG_CEH;
            S_MG_CEH: st_nxt = S_MG_END;
            S_MG_END: begin
               if (mg_q) st_nxt = S_B_RDSET;
               else begin
                  st_nxt = S_RB_VCC;
                  a_clr  = 1'b1;
               end
            end
            S_B_RDSET: st_nxt = S_B_RDCE;
            S_B_RDCE: begin
               cap    = 1'b1;
               st_nxt = S_B_RDEND;
            end
            S_B_RDEND: begin
               if (cmp_match) begin
                  t_clr = 1'b1;
                  if (a_last) begin
                     mg_off = 1'b1;
                     st_nxt = S_MG_A9;
                  end else begin
                     a_inc  = 1'b1;
                     st_nxt = S_B_RDSET;
                  end
               end else if (cmp_unprog) begin
                  err_ld = 1'b1;
                  err_v  = ERR_UNPROG;
                  st_nxt = S_FAIL;
               end else if (tries == TRY_W'(MAX_PULSES)) begin
                  err_ld = 1'b1;
                  err_v  = ERR_RETRY;
                  st_nxt = S_FAIL;
               end else begin
                  st_nxt = S_B_LOAD;
               end
            end
            S_B_LOAD:  st_nxt = S_B_PULSE;
            S_B_PULSE: st_nxt = S_B_HOLD;
            S_B_HOLD: begin
               t_inc  = 1'b1;
               st_nxt = S_B_RDSET;
            end
            S_RB_VCC: st_nxt = S_RB_RD;
            S_RB_RD: begin
               cap    = 1'b1;
               st_nxt = S_RB_END;
            end
            S_RB_END: begin
               if (!cmp_match) begin
                  err_ld = 1'b1;
                  err_v  = ERR_READBACK;
                  st_nxt = S_FAIL;
               end else if (!a_last) begin
                  a_inc  = 1'b1;
                  st_nxt = S_RB_RD;
               end else if (!rb_q) begin
                  rb_next = 1'b1;
                  a_clr   = 1'b1;
                  st_nxt  = S_RB_VCC;
               end else begin
                  st_nxt = S_DONE;
               end
            end
            default: st_nxt = S_IDLE;
         endcase
      end
   end

   // ---------------- registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         mg_q      <= 1'b0;
         rb_q      <= 1'b0;
         tries     <= '0;
         rd_q      <= '0;
         err_q     <= ERR_NONE;
         fail_addr <= '0;
      end else begin
         st <= st_nxt;
         if (mg_on)        mg_q <= 1'b1;
         else if (mg_off)  mg_q <= 1'b0;
         if (rb_clr)       rb_q <= 1'b0;
         else if (rb_next) rb_q <= 1'b1;
         if (t_clr)        tries <= '0;
         else if (t_inc)   tries <= tries + 1'b1;
         if (cap)          rd_q <= dq_in;
         if (rb_clr)       err_q <= ERR_NONE;
         else if (err_ld) begin
            err_q     <= err_v;
            fail_addr <= dev_addr;
         end
      end
   end

   // ---------------- pin levels per state ----------------
   always_comb begin
      ce_n    = 1'b1;
      dq_oe   = 1'b0;
      a9_hv   = 1'b0;
      a10_lvl = 1'b0;
      vpp_q   = VPP_HIGH;
      vcc_q   = VCC_NOM;
      unique case (st)
         S_MG_A9:  begin a9_hv = 1'b1; vcc_q = VCC_PROG; end
         S_MG_VPP: begin a9_hv = 1'b1; vcc_q = VCC_PROG; vpp_q = VPP_PROG; end
         S_MG_CEL: begin a9_hv = 1'b1; vcc_q = VCC_PROG; vpp_q = VPP_PROG; ce_n = 1'b0; end
         S_MG_A10: begin
            a9_hv = 1'b1; vcc_q = VCC_PROG; vpp_q = VPP_PROG; ce_n = 1'b0; a10_lvl = mg_q;
         end
         S_MG_CEH: begin a9_hv = 1'b1; vcc_q = VCC_PROG; vpp_q = VPP_PROG; a10_lvl = mg_q; end
         S_MG_END: begin a9_hv = 1'b1; vcc_q = VCC_PROG; end
         S_B_RDSET: begin vcc_q = VCC_PROG; vpp_q = VPP_LOW; end
         S_B_RDCE:  begin vcc_q = VCC_PROG; vpp_q = VPP_LOW; ce_n = 1'b0; end
         S_B_RDEND: begin vcc_q = VCC_PROG; vpp_q = VPP_LOW; end
         S_B_LOAD:  begin vcc_q = VCC_PROG; vpp_q = VPP_PROG; dq_oe = 1'b1; end
         S_B_PULSE: begin vcc_q = VCC_PROG; vpp_q = VPP_PROG; dq_oe = 1'b1; ce_n = 1'b0; end
         S_B_HOLD:  begin vcc_q = VCC_PROG; vpp_q = VPP_PROG; dq_oe = 1'b1; end
         S_RB_VCC:  vcc_q = rb_q ? VCC_LO : VCC_HI;
         S_RB_RD:   begin vcc_q = rb_q ? VCC_LO : VCC_HI; vpp_q = VPP_LOW; ce_n = 1'b0; end
         S_RB_END:  vcc_q = rb_q ? VCC_LO : VCC_HI;
         default: ;
      endcase
   end

   assign vpp_sel   = vpp_q;
   assign vcc_sel   = vcc_q;
   assign src_addr  = dev_addr;
   assign dq_out    = dq_oe ? src_data : '0;
   assign done      = (st == S_DONE);
   assign fail      = (st == S_FAIL);
   assign fail_code = err_q;

   // cycles chip enable has been low, for the pulse width check
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pw <= '0;
      else if (ce_n)       pw <= '0;
      else if (pw != '1)   pw <= pw + 1'b1;
   end

   // ---------------- assertions ----------------
   assert_read_no_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_sel == VPP_LOW) |-> !dq_oe);

   assert_pulse_at_vpp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && dq_oe) |-> (vpp_sel == VPP_PROG && !a9_hv));

   assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ce_n) && $past(dq_oe)) |-> (pw == CW'(TP_CYC)));

   assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && $past(!ce_n)) |-> $stable(dev_addr));

   assert_a10_under_a9_R2: assert property (@(posedge clk) disable iff (!rst_n)
      a10_lvl |-> a9_hv);

   assert_vpp_at_prog_vcc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_sel == VPP_PROG) |-> (vcc_sel == VCC_PROG));

   assert_tries_capped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tries <= TRY_W'(MAX_PULSES));

   assert_fail_addr_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && $past(fail)) |-> $stable(fail_addr));

endmodule

// File: tb/sim_eprom_burn_seq.sv
module sim_eprom_burn_seq;

   localparam int AW = 4;
   localparam int DW = 8;
   localparam int T1 = 2;
   localparam int T2 = 3;
   localparam int TP = 6;
   localparam int TV = 2;
   localparam int TZ = 1;
   localparam int MAXP = 4;
   localparam int N = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] src_addr, dev_addr, fail_addr;
   logic [DW-1:0] src_data, dq_out, dq_in;
   logic dq_oe, ce_n, a9_hv, a10_lvl, done, fail;
   logic [1:0] vpp_sel, vcc_sel, fail_code;

   always #4 clk = ~clk;

   eprom_burn_seq #(.AW(AW), .DW(DW), .T1_CYC(T1), .T2_CYC(T2), .TP_CYC(TP),
                    .TV_CYC(TV), .TZ_CYC(TZ), .MAX_PULSES(MAXP)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr), .src_data(src_data),
      .dev_addr(dev_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .ce_n(ce_n),
      .vpp_sel(vpp_sel), .a9_hv(a9_hv), .a10_lvl(a10_lvl), .vcc_sel(vcc_sel),
      .done(done), .fail(fail), .fail_code(fail_code), .fail_addr(fail_addr)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- device model ----------------
   logic [DW-1:0] want [N];
   logic [DW-1:0] mem  [N];
   int need [N];
   int pulses [N];
   int rb_hi, rb_lo, vfy, weak_a;
   bit margin;

   assign src_data = want[src_addr];
   assign dq_in = (!ce_n && vpp_sel == 2'b00 && !dq_oe) ?
                  ((weak_a == int'(dev_addr) && vcc_sel == 2'b11) ? 8'hFF : mem[dev_addr]) : 8'h00;

   logic p_ce = 1'b1, p_oe = 1'b0, p_a9 = 1'b0, p_a10 = 1'b0;
   logic [1:0] p_vpp = 2'b01;
   logic [AW-1:0] p_addr = '0;
   logic [DW-1:0] p_dq = '0;
   int age_addr, age_vpp, age_a9, age_a10, age_ce, age_oe, lo_len;

   always @(negedge clk) begin
      if (rst_n) begin
         age_addr = (dev_addr != p_addr) ? 0 : age_addr + 1;
         age_vpp  = (vpp_sel  != p_vpp)  ? 0 : age_vpp + 1;
         age_a9   = (a9_hv    != p_a9)   ? 0 : age_a9 + 1;
         age_a10  = (a10_lvl  != p_a10)  ? 0 : age_a10 + 1;
         age_ce   = (ce_n     != p_ce)   ? 0 : age_ce + 1;
         age_oe   = (dq_oe    != p_oe)   ? 0 : age_oe + 1;
         lo_len   = ce_n ? 0 : (p_ce ? 1 : lo_len + 1);
         // R2: program voltage only after A9 high has settled
         if (vpp_sel == 2'b10 && p_vpp != 2'b10 && a9_hv)
            chk(age_a9 >= T2, "R2 A9 setup before program voltage", age_a9, T2);
         // chip enable falls
         if (!ce_n && p_ce) begin
            if (vpp_sel == 2'b10) chk(age_vpp >= T2, "R2/R3 program voltage setup", age_vpp, T2);
            if (dq_oe) begin
               chk(age_addr >= T2, "R3 address setup", age_addr, T2);
               chk(age_oe >= T2, "R3 data setup", age_oe, T2);
            end
            if (vpp_sel == 2'b00) begin
               chk(!dq_oe, "R11 driver off in read", dq_oe, 0);
               if (vcc_sel == 2'b01) begin
                  vfy++;
                  chk(margin, "R4 verify in margin mode", margin, 1);
               end else begin
                  chk(!margin, "R8 read-back with margin off", margin, 0);
                  if (vcc_sel == 2'b10) begin
                     rb_hi++;
                     chk(rb_lo == 0, "R9 raised supply pass first", rb_lo, 0);
                  end
                  if (vcc_sel == 2'b11) rb_lo++;
               end
            end
         end
         // chip enable rises
         if (ce_n && !p_ce) begin
            if (p_oe && p_vpp == 2'b10 && !p_a9) begin
               chk(lo_len == 0 && age_ce == 0, "R3 edge bookkeeping", age_ce, 0);
               pulses[p_addr]++;
               chk(margin, "R2 pulse after margin set", margin, 1);
               if (pulses[p_addr] >= need[p_addr]) mem[p_addr] = mem[p_addr] & p_dq;
            end else if (p_a9 && p_vpp == 2'b10) begin
               if (p_a10) chk(age_a10 >= T1, "R2 A10 setup before chip enable rise", age_a10, T1);
               margin = p_a10;
            end
         end
         // R3 pulse width, counted up to the last low cycle
         if (ce_n && !p_ce && p_oe)
            chk(pw_seen == TP, "R3 pulse width", pw_seen, TP);
         if (!dq_oe && p_oe)
            chk(age_ce >= T2, "R3 data hold after chip enable rise", age_ce, T2);
         pw_seen = ce_n ? pw_seen : lo_len;
         if (!ce_n && !p_ce && dev_addr != p_addr)
            chk(0, "R3 address moved under chip enable", dev_addr, p_addr);
         p_ce = ce_n; p_oe = dq_oe; p_a9 = a9_hv; p_a10 = a10_lvl;
         p_vpp = vpp_sel; p_addr = dev_addr; p_dq = dq_out;
      end
   end
   int pw_seen = 0;

   task automatic prep();
      for (int a = 0; a < N; a++) begin
         mem[a]    = 8'hFF;
         pulses[a] = 0;
         need[a]   = (a % 3) + 1;
         want[a]   = 8'(((a * 29) + 8'h13) ^ 8'hA5);
      end
      want[15] = 8'hFF;
      rb_hi = 0; rb_lo = 0; vfy = 0; weak_a = -1;
   endtask

   task automatic run_seq();
      int cyc;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      cyc = 0;
      while (!(done || fail) && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      if (cyc >= 20000) chk(0, "R10 run did not end", cyc, 20000);
      repeat (3) @(negedge clk);
   endtask

   task automatic idle_pins(input string tag);
      chk(ce_n == 1'b1, {tag, " ce_n"}, ce_n, 1);
      chk(dq_oe == 1'b0, {tag, " dq_oe"}, dq_oe, 0);
      chk(vpp_sel == 2'b01, {tag, " vpp_sel"}, vpp_sel, 1);
      chk(a9_hv == 1'b0 && a10_lvl == 1'b0, {tag, " a9/a10"}, {a9_hv, a10_lvl}, 0);
      chk(vcc_sel == 2'b00, {tag, " vcc_sel"}, vcc_sel, 0);
   endtask

   initial begin
      int exp_p, exp_v;
      prep();
      margin = 1'b0;
      age_addr = 0; age_vpp = 0; age_a9 = 0; age_a10 = 0; age_ce = 0; age_oe = 0; lo_len = 0;
      repeat (4) @(negedge clk);
      idle_pins("R1 in reset");
      chk(!done && !fail, "R1 no status in reset", {done, fail}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      idle_pins("R1 after reset");

      // run A: full array, varied pulse needs, one byte left erased
      run_seq();
      chk(done && !fail, "R10 done after clean run", {done, fail}, 2);
      idle_pins("R1 done state");
      exp_v = 0;
      for (int a = 0; a < N; a++) begin
         exp_p = (want[a] == 8'hFF) ? 0 : need[a];
         exp_v += exp_p + 1;
         chk(mem[a] == want[a], $sformatf("R5 byte %0d content", a), mem[a], want[a]);
         chk(pulses[a] == exp_p, $sformatf("R5 byte %0d pulse count", a), pulses[a], exp_p);
      end
      chk(vfy == exp_v, "R4 verify reads", vfy, exp_v);
      chk(rb_hi == N, "R9 raised supply reads", rb_hi, N);
      chk(rb_lo == N, "R9 lowered supply reads", rb_lo, N);
      repeat (5) @(negedge clk);
      chk(done, "R10 done held", done, 1);

      // run B: retry limit at address 5
      prep();
      need[5] = MAXP + 1;
      run_seq();
      chk(fail && !done, "R6 fail raised", {done, fail}, 1);
      chk(fail_code == 2'b01, "R6 fail code", fail_code, 1);
      chk(fail_addr == 4'd5, "R6 fail address", fail_addr, 5);
      chk(pulses[5] == MAXP, "R6 pulses at limit", pulses[5], MAXP);
      chk(pulses[6] == 0, "R6 nothing after stop", pulses[6], 0);
      chk(mem[4] == want[4], "R5 earlier byte kept", mem[4], want[4]);
      idle_pins("R1 fail state");

      // run C: unprogrammable byte at address 7
      prep();
      mem[7]  = 8'h0F;
      want[7] = 8'hF0;
      run_seq();
      chk(fail_code == 2'b10, "R7 fail code", fail_code, 2);
      chk(fail_addr == 4'd7, "R7 fail address", fail_addr, 7);
      chk(pulses[7] == 0, "R7 no pulse on stuck byte", pulses[7], 0);
      chk(mem[7] == 8'h0F, "R7 cell untouched", mem[7], 8'h0F);
      repeat (6) @(negedge clk);
      chk(fail && fail_addr == 4'd7, "R10 fail held", fail_addr, 7);

      // run D: cell weak at the lowered supply
      prep();
      weak_a = 9;
      run_seq();
      chk(fail_code == 2'b11, "R9 read-back fail code", fail_code, 3);
      chk(fail_addr == 4'd9, "R9 read-back fail address", fail_addr, 9);
      chk(rb_hi == N, "R9 raised pass complete", rb_hi, N);
      chk(rb_lo == 10, "R9 lowered pass stops at weak cell", rb_lo, 10);

      // run E: restart from fail ends clean
      prep();
      run_seq();
      chk(done && !fail, "R10 restart after fail", {done, fail}, 2);
      chk(fail_code == 2'b00, "R10 fail code cleared", fail_code, 0);
      chk(pulses[15] == 0, "R5 erased byte unpulsed", pulses[15], 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule